// File: doc/BRIEF.md
# CAN Fault Confinement Unit

This block keeps the two error counters of a CAN node and derives from them the node's fault-confinement state. The protocol engine sends it single-cycle pulses for transmit errors, receive errors, good transmissions and good receptions. The unit updates the transmit error count (TEC) and the receive error count (REC). It reports whether the node is error-active, error-passive or bus-off. It also raises interrupt request pulses for bus errors and for changes of the warning status.

Bus-off is reached only when a transmit error arrives while TEC already holds its top value of 255. On that event the node enters bus-off and reset mode together, TEC is loaded with 127 and REC is cleared. The node then stays silent until software clears reset mode. After that release, the unit watches the sampled bus bit on each bit-time strobe. It counts runs of 11 recessive bits, which form a bus-free occurrence. Each occurrence lowers TEC by one, so TEC shows how far recovery has come. The 128th occurrence returns the node to bus-on with both counters at zero.

Top module: `can_fault_conf`

## Requirements
- R1: After reset, TEC and REC are 0, state_o is 0, bus_off_o, reset_mode_o and err_stat_o are low, and both interrupt outputs are low.
- R2: An accepted transmit error adds 8 to TEC, saturating at 255. A good transmission subtracts 1, stopping at 0. A receive error adds 1 to REC, saturating at 255. A good reception subtracts 1, stopping at 0. All results are visible on the clock edge that samples the pulse.
- R3: state_o encodes the node state as 0 for error-active, 1 for error-passive and 2 for bus-off. Outside bus-off, the state is error-passive exactly when TEC or REC is above 127.
- R4: A transmit error that arrives while TEC is 255 enters bus-off. On the same edge, bus_off_o and reset_mode_o rise, TEC becomes 127 and REC becomes 0. Reaching 255 does not by itself enter bus-off.
- R5: When bus_err_en_i is high, irq_buserr_o pulses for one cycle after each accepted transmit or receive error, including the error that causes bus-off.
- R6: err_stat_o is high while the node is bus-off or while either counter is at or above 96. When warn_en_i is high, irq_warn_o pulses for one cycle on every change of err_stat_o.
- R7: While bus_off_o or reset_mode_o is high, error and success pulses change neither counter and raise no bus-error interrupt.
- R8: While reset_mode_o is high, bus_off_o stays high and TEC does not change, whatever the bus carries. A pulse on rm_clear_i clears reset mode.
- R9: After reset mode is cleared, a bus-free occurrence is 11 consecutive recessive bits (bus_bit_i = 1) taken on bit_stb_i. A dominant bit restarts the run, and cycles without the strobe are ignored. Each occurrence lowers TEC by 1.
- R10: On the 128th bus-free occurrence after release, bus_off_o falls and TEC and REC are 0. err_stat_o then follows the counters again and falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_err_i | input | 1 | Transmit error pulse |
| tx_ok_i | input | 1 | Successful transmission pulse |
| rx_err_i | input | 1 | Receive error pulse |
| rx_ok_i | input | 1 | Successful reception pulse |
| bit_stb_i | input | 1 | Bit-time sample strobe |
| bus_bit_i | input | 1 | Sampled bus level, 1 = recessive |
| rm_clear_i | input | 1 | Software release of reset mode |
| bus_err_en_i | input | 1 | Bus-error interrupt enable |
| warn_en_i | input | 1 | Error-warning interrupt enable |
| tec_o | output | 8 | Transmit error count |
| rec_o | output | 8 | Receive error count |
| state_o | output | 2 | Node state code |
| bus_off_o | output | 1 | Bus status, 1 = bus-off |
| reset_mode_o | output | 1 | Reset mode active |
| err_stat_o | output | 1 | Error warning status |
| irq_buserr_o | output | 1 | Bus-error interrupt pulse |
| irq_warn_o | output | 1 | Error-warning interrupt pulse |

## Verification
The bench builds the unit with its default parameters: 8-bit counters, an 11-bit bus-free run and 128 recovery occurrences. With these values, a full recovery takes at least 1408 strobed bits, so directed runs and random runs both reach bus-off and complete the full countdown back to bus-on. Using the real limits means the corner cases are tested at the values that matter. These include the 255 saturation without bus-off, the 127 preload, the switch at the 96 warning limit and the passive boundary at 127/128. Random periods of dominant bits check that a run restarts after a dominant bit.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'd0,
    FC_PASSIVE = 2'd1,
    FC_BUSOFF  = 2'd2
  } fc_state_e;
endpackage

// File: rtl/can_fc_idle_det.sv
// Counts consecutive recessive strobed bits; pulses once per complete run.
module can_fc_idle_det #(
  parameter int IDLE_BITS = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic bit_stb,
  input  logic bus_bit,
  output logic seq_o
);
  localparam int RW = $clog2(IDLE_BITS + 1);
  localparam logic [RW-1:0] LAST = RW'(IDLE_BITS - 1);

  logic [RW-1:0] run_q;

  assign seq_o = en && bit_stb && bus_bit && (run_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      run_q <= '0;
    end else if (bit_stb) begin
      if (!bus_bit || run_q == LAST) run_q <= '0;
      else                           run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/can_fc_recovery.sv
// Counts bus-free occurrences after release; flags the final one.
module can_fc_recovery #(
  parameter int RECOV_SEQ = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic seq,
  output logic dec_o,
  output logic done_o
);
  localparam int CW = $clog2(RECOV_SEQ + 1);
  localparam logic [CW-1:0] LAST = CW'(RECOV_SEQ - 1);

  logic [CW-1:0] cnt_q;

  assign dec_o  = en && seq;
  assign done_o = dec_o && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !en || done_o) cnt_q <= '0;
    else if (dec_o)           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/can_fc_counters.sv
// Transmit and receive error counters with saturation and bus-off preload.
module can_fc_counters #(
  parameter int CNT_W   = 8,
  parameter int TX_INC  = 8,
  parameter int PRESET  = 127
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_en,
  input  logic             tx_err,
  input  logic             tx_ok,
  input  logic             rx_err,
  input  logic             rx_ok,
  input  logic             rcv_dec,
  input  logic             rcv_done,
  output logic             bo_hit_o,
  output logic [CNT_W-1:0] tec_q_o,
  output logic [CNT_W-1:0] rec_q_o,
  output logic [CNT_W-1:0] tec_d_o,
  output logic [CNT_W-1:0] rec_d_o
);
  localparam logic [CNT_W-1:0] TOP    = '1;
  localparam logic [CNT_W-1:0] INC    = CNT_W'(TX_INC);
  localparam logic [CNT_W-1:0] INC_LIM = TOP - INC;
  localparam logic [CNT_W-1:0] LOAD   = CNT_W'(PRESET);

  logic [CNT_W-1:0] tec_q, rec_q, tec_d, rec_d;

  assign bo_hit_o = ev_en && tx_err && (tec_q == TOP);

  always_comb begin
    tec_d = tec_q;
    rec_d = rec_q;
    if (ev_en) begin
      if (tx_err)     tec_d = (tec_q > INC_LIM) ? TOP : tec_q + INC;
      else if (tx_ok) tec_d = (tec_q == '0) ? '0 : tec_q - 1'b1;
      if (rx_err)     rec_d = (rec_q == TOP) ? TOP : rec_q + 1'b1;
      else if (rx_ok) rec_d = (rec_q == '0) ? '0 : rec_q - 1'b1;
    end
    if (bo_hit_o) begin
      tec_d = LOAD;
      rec_d = '0;
    end else if (rcv_done) begin
      tec_d = '0;
      rec_d = '0;
    end else if (rcv_dec) begin
      tec_d = (tec_q == '0) ? '0 : tec_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tec_q <= '0;
      rec_q <= '0;
    end else begin
      tec_q <= tec_d;
      rec_q <= rec_d;
    end
  end

  assign tec_q_o = tec_q;
  assign rec_q_o = rec_q;
  assign tec_d_o = tec_d;
  assign rec_d_o = rec_d;
endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf #(
  parameter int CNT_W     = 8,
  parameter int TX_INC    = 8,
  parameter int PASS_LIM  = 127,
  parameter int WARN_LIM  = 96,
  parameter int BO_PRESET = 127,
  parameter int IDLE_BITS = 11,
  parameter int RECOV_SEQ = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_err_i,
  input  logic             tx_ok_i,
  input  logic             rx_err_i,
  input  logic             rx_ok_i,
  input  logic             bit_stb_i,
  input  logic             bus_bit_i,
  input  logic             rm_clear_i,
  input  logic             bus_err_en_i,
  input  logic             warn_en_i,
  output logic [CNT_W-1:0] tec_o,
  output logic [CNT_W-1:0] rec_o,
  output logic [1:0]       state_o,
  output logic             bus_off_o,
  output logic             reset_mode_o,
  output logic             err_stat_o,
  output logic             irq_buserr_o,
  output logic             irq_warn_o
);
  import can_fc_pkg::*;

  localparam logic [CNT_W-1:0] PLIM = CNT_W'(PASS_LIM);
  localparam logic [CNT_W-1:0] WLIM = CNT_W'(WARN_LIM);

  logic bo_q, rm_q, est_q, irq_be_q, irq_w_q;
  fc_state_e st_q, st_d;
  logic bo_d, rm_d, est_d;
  logic ev_en, rcv_en, seq, rcv_dec, rcv_done, bo_hit;
  logic [CNT_W-1:0] tec_q, rec_q, tec_d, rec_d;

  assign ev_en  = !bo_q && !rm_q;
  assign rcv_en = bo_q && !rm_q;

  can_fc_idle_det #(.IDLE_BITS(IDLE_BITS)) u_idle (
    .clk(clk), .rst(rst), .en(rcv_en), .bit_stb(bit_stb_i),
    .bus_bit(bus_bit_i), .seq_o(seq)
  );

  can_fc_recovery #(.RECOV_SEQ(RECOV_SEQ)) u_rcv (
    .clk(clk), .rst(rst), .en(rcv_en), .seq(seq),
    .dec_o(rcv_dec), .done_o(rcv_done)
  );

  can_fc_counters #(.CNT_W(CNT_W), .TX_INC(TX_INC), .PRESET(BO_PRESET)) u_cnt (
    .clk(clk), .rst(rst), .ev_en(ev_en),
    .tx_err(tx_err_i), .tx_ok(tx_ok_i), .rx_err(rx_err_i), .rx_ok(rx_ok_i),
    .rcv_dec(rcv_dec), .rcv_done(rcv_done), .bo_hit_o(bo_hit),
    .tec_q_o(tec_q), .rec_q_o(rec_q), .tec_d_o(tec_d), .rec_d_o(rec_d)
  );

  always_comb begin
    bo_d = bo_q;
    if (bo_hit)        bo_d = 1'b1;
    else if (rcv_done) bo_d = 1'b0;
    rm_d = rm_q;
    if (bo_hit)          rm_d = 1'b1;
    else if (rm_clear_i) rm_d = 1'b0;
    est_d = bo_d || (tec_d >= WLIM) || (rec_d >= WLIM);
    if (bo_d)                               st_d = FC_BUSOFF;
    else if ((tec_d > PLIM) || (rec_d > PLIM)) st_d = FC_PASSIVE;
    else                                    st_d = FC_ACTIVE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bo_q     <= 1'b0;
      rm_q     <= 1'b0;
      est_q    <= 1'b0;
      st_q     <= FC_ACTIVE;
      irq_be_q <= 1'b0;
      irq_w_q  <= 1'b0;
    end else begin
      bo_q     <= bo_d;
      rm_q     <= rm_d;
      est_q    <= est_d;
      st_q     <= st_d;
      irq_be_q <= bus_err_en_i && ev_en && (tx_err_i || rx_err_i);
      irq_w_q  <= warn_en_i && (est_d != est_q);
    end
  end

  assign tec_o        = tec_q;
  assign rec_o        = rec_q;
  assign state_o      = st_q;
  assign bus_off_o    = bo_q;
  assign reset_mode_o = rm_q;
  assign err_stat_o   = est_q;
  assign irq_buserr_o = irq_be_q;
  assign irq_warn_o   = irq_w_q;
endmodule

// File: rtl/can_fault_conf_chk.sv
module can_fault_conf_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             tx_err_i,
  input logic             rx_err_i,
  input logic [CNT_W-1:0] tec_o,
  input logic [CNT_W-1:0] rec_o,
  input logic [1:0]       state_o,
  input logic             bus_off_o,
  input logic             reset_mode_o,
  input logic             err_stat_o,
  input logic             irq_buserr_o
);
  // R4
  rm_with_bo_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(reset_mode_o) |-> $rose(bus_off_o));
  // R4
  bo_load_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_off_o) |-> (tec_o == CNT_W'(127) && rec_o == '0 && $past(tx_err_i)));
  // R3
  state_code_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_off_o == (state_o == 2'd2)) && state_o != 2'd3);
  // R6
  bo_warn_chk: assert property (@(posedge clk) disable iff (rst)
    bus_off_o |-> err_stat_o);
  // R5
  be_cause_chk: assert property (@(posedge clk) disable iff (rst)
    irq_buserr_o |-> $past(tx_err_i || rx_err_i));
  // R8
  rm_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (reset_mode_o && $past(reset_mode_o)) |-> (bus_off_o && $stable(tec_o)));
  // R7
  rec_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_off_o && $past(bus_off_o)) |-> $stable(rec_o));
  // R2
  tec_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_off_o && (tec_o > $past(tec_o))) |-> $past(tx_err_i));
endmodule

bind can_fault_conf can_fault_conf_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .tx_err_i(tx_err_i), .rx_err_i(rx_err_i),
  .tec_o(tec_o), .rec_o(rec_o), .state_o(state_o), .bus_off_o(bus_off_o),
  .reset_mode_o(reset_mode_o), .err_stat_o(err_stat_o),
  .irq_buserr_o(irq_buserr_o)
);

// File: tb/can_fault_conf_test.sv
`timescale 1ns/1ps
module can_fault_conf_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_err = 0, tx_ok = 0, rx_err = 0, rx_ok = 0;
  logic stb = 0, bbit = 1, clr = 0, be_en = 0, w_en = 0;
  logic [7:0] tec, rec;
  logic [1:0] st;
  logic bo, rm, est, irqb, irqw;

  int total = 0;
  int bad = 0;
  bit done_flag = 0;

  // bench reference state
  int m_tec = 0, m_rec = 0, m_run = 0, m_seq = 0, m_st = 0;
  bit m_bo = 0, m_rm = 0, m_est = 0, m_irqb = 0, m_irqw = 0;

  always #2.5 clk = ~clk;

  can_fault_conf uut (
    .clk(clk), .rst(rst), .tx_err_i(tx_err), .tx_ok_i(tx_ok),
    .rx_err_i(rx_err), .rx_ok_i(rx_ok), .bit_stb_i(stb), .bus_bit_i(bbit),
    .rm_clear_i(clr), .bus_err_en_i(be_en), .warn_en_i(w_en),
    .tec_o(tec), .rec_o(rec), .state_o(st), .bus_off_o(bo),
    .reset_mode_o(rm), .err_stat_o(est), .irq_buserr_o(irqb), .irq_warn_o(irqw)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int sat_add(input int v, input int d);
    return (v + d > 255) ? 255 : v + d;
  endfunction
  function automatic int dec0(input int v);
    return (v == 0) ? 0 : v - 1;
  endfunction

  task automatic ref_update(input bit te, to, re, ro, sb, bb, cl);
    bit ev, hit, n_est;
    ev = !m_bo && !m_rm;
    hit = 0;
    m_irqb = be_en && ev && (te || re);
    if (ev) begin
      if (te) begin
        if (m_tec == 255) hit = 1;
        else m_tec = sat_add(m_tec, 8);
      end else if (to) m_tec = dec0(m_tec);
      if (re) m_rec = sat_add(m_rec, 1);
      else if (ro) m_rec = dec0(m_rec);
    end
    if (m_bo && !m_rm) begin
      if (sb) begin
        if (!bb) m_run = 0;
        else if (m_run == 10) begin
          m_run = 0;
          m_seq++;
          m_tec = dec0(m_tec);
          if (m_seq == 128) begin
            m_bo = 0; m_tec = 0; m_rec = 0; m_seq = 0;
          end
        end else m_run++;
      end
    end else begin
      m_run = 0;
      m_seq = 0;
    end
    if (hit) begin
      m_bo = 1; m_rm = 1; m_tec = 127; m_rec = 0;
    end else if (cl) m_rm = 0;
    n_est = m_bo || m_tec >= 96 || m_rec >= 96;
    m_irqw = w_en && (n_est != m_est);
    m_est = n_est;
    m_st = m_bo ? 2 : ((m_tec > 127 || m_rec > 127) ? 1 : 0);
  endtask

  task automatic compare_all();
    chk(int'(tec) == m_tec, "R2 tec", int'(tec), m_tec);
    chk(int'(rec) == m_rec, "R2 rec", int'(rec), m_rec);
    chk(int'(st) == m_st, "R3 state", int'(st), m_st);
    chk(bo == m_bo, "R4 bus_off", int'(bo), int'(m_bo));
    chk(rm == m_rm, "R8 reset_mode", int'(rm), int'(m_rm));
    chk(est == m_est, "R6 err_stat", int'(est), int'(m_est));
    chk(irqb == m_irqb, "R5 irq_buserr", int'(irqb), int'(m_irqb));
    chk(irqw == m_irqw, "R6 irq_warn", int'(irqw), int'(m_irqw));
  endtask

  // called at a falling edge: drive, pass a rising edge, compare at next falling edge
  task automatic step(input bit te, to, re, ro, sb, bb, cl);
    tx_err = te; tx_ok = to; rx_err = re; rx_ok = ro;
    stb = sb; bbit = bb; clr = cl;
    @(posedge clk);
    ref_update(te, to, re, ro, sb, bb, cl);
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle_bits(input int n, input bit level);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 1, level, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done_flag) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    be_en = 1; w_en = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk(tec == 0 && rec == 0 && st == 0, "R1 counters/state", int'(tec) + int'(rec) + int'(st), 0);
    chk({bo, rm, est, irqb, irqw} == 5'b0, "R1 flags", int'({bo, rm, est, irqb, irqw}), 0);

    // R2 / R3: climb to 255 without bus-off
    for (int i = 0; i < 32; i++) step(1, 0, 0, 0, 0, 1, 0);
    chk(tec == 255 && bo == 0, "R4 at 255 not bus-off", int'(bo), 0);
    chk(st == 1, "R3 passive at 255", int'(st), 1);
    step(0, 0, 1, 0, 0, 1, 0);
    // R4 entry
    step(1, 0, 0, 0, 0, 1, 0);
    chk(bo && rm && tec == 127 && rec == 0, "R4 entry load", int'(tec), 127);
    chk(irqb == 1, "R5 bus-error pulse on entry", int'(irqb), 1);
    // R7 events ignored
    step(0, 1, 0, 0, 0, 1, 0);
    step(1, 0, 0, 0, 0, 1, 0);
    step(0, 0, 1, 0, 0, 1, 0);
    chk(tec == 127 && rec == 0 && irqb == 0, "R7 ignored in bus-off", int'(tec), 127);
    // R8 no recovery while held
    idle_bits(40, 1);
    chk(tec == 127 && bo == 1, "R8 held in reset mode", int'(tec), 127);
    // release, then R9 run semantics
    step(0, 0, 0, 0, 0, 1, 1);
    chk(rm == 0 && bo == 1, "R8 release keeps bus-off", int'(rm), 0);
    idle_bits(10, 1);
    idle_bits(1, 0);
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 0, 1, 0);
    idle_bits(10, 1);
    chk(tec == 127, "R9 dominant restarts run", int'(tec), 127);
    idle_bits(1, 1);
    chk(tec == 126, "R9 one occurrence", int'(tec), 126);
    idle_bits(11 * 126, 1);
    chk(bo == 1 && tec == 0, "R9 after 127 occurrences", int'(bo), 1);
    idle_bits(11, 1);
    chk(bo == 0 && tec == 0 && rec == 0 && est == 0, "R10 recovery done", int'(bo), 0);
    chk(irqw == 1, "R10 warning pulse on recovery", int'(irqw), 1);

    // random mix
    for (int i = 0; i < 60000; i++) begin
      int r;
      bit te, to, re, ro, sb, bb, cl;
      r = $urandom_range(0, 99);
      te = 0; to = 0; re = 0; ro = 0;
      if (r < 14) te = 1;
      else if (r < 20) to = 1;
      else if (r < 32) re = 1;
      else if (r < 40) ro = 1;
      sb = ($urandom_range(0, 1) == 1);
      bb = ($urandom_range(0, 99) < 92);
      cl = ($urandom_range(0, 99) < 2);
      if ($urandom_range(0, 199) == 0) be_en = ~be_en;
      if ($urandom_range(0, 199) == 0) w_en = ~w_en;
      step(te, to, re, ro, sb, bb, cl);
    end

    done_flag = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    process p;
    p = process::self();
    p.srandom(32'd1187);
  end
endmodule